// File: doc/BRIEF.md
# Write Protection Decision Unit

This unit sits beside the command decoder of a serial non-volatile memory. For every write request it decides whether the memory array and the status register may be modified. It also holds the write-enable latch. A write-enable command sets the latch. A write-disable command, or the end of an internal write cycle, clears it.

A status bit (`prot_en`) can arm the external write-protect pin. When it is armed, a low pin freezes the status register. A two-bit block level marks an upper range of the 16 KB array as permanently read-only, whatever the other inputs are. Both permits are combinational from the current request and the held state, so the decoder can act on them in the same cycle it presents the address.

Top module: `wp_decision_unit`

## Requirements
- R1: While `rst` is high at a rising edge, and after it, the latch reads 0 and both permits read 0 until a set command is accepted.
- R2: A high `cmd_set_wel` at a rising edge, with neither clear source high, makes `wel` read 1 from that edge on.
- R3: A high `cmd_clr_wel` or a high `wr_cycle_done` at a rising edge makes `wel` read 0 from that edge on. A clear wins over a set in the same cycle.
- R4: While `wel` is 0, `array_wr_ok` and `status_wr_ok` are both 0, for every pin, `prot_en`, level and address.
- R5: With `prot_en` = 0 the pin has no effect. With `wel` = 1, `status_wr_ok` is 1, and `array_wr_ok` is 1 for addresses outside the protected field.
- R6: With `prot_en` = 1 and the synchronised pin low, `status_wr_ok` is 0 even when `wel` = 1. `array_wr_ok` still follows the protected-field test.
- R7: With the synchronised pin high and `wel` = 1, `status_wr_ok` is 1 for either value of `prot_en`.
- R8: `blk_lvl` codes: 0 protects nothing; 1 protects byte addresses 0x3000–0x3FFF; 2 protects 0x2000–0x3FFF; 3 protects 0x0000–0x3FFF. Only `wr_addr[13:0]` counts, and bits 15:14 are ignored. `array_wr_ok` is 0 for every address inside the field.
- R9: The pin passes through two flip-flops. A pin change driven between edges affects `status_wr_ok` after the second following rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Asynchronous write-protect pin, low = protect |
| prot_en | input | 1 | Status bit that arms the pin |
| blk_lvl | input | 2 | Block protection level |
| wr_addr | input | 16 | Target byte address of the request |
| cmd_set_wel | input | 1 | Write-enable command pulse |
| cmd_clr_wel | input | 1 | Write-disable command pulse |
| wr_cycle_done | input | 1 | Internal write cycle completed pulse |
| wel | output | 1 | Write-enable latch |
| array_wr_ok | output | 1 | Array write permitted |
| status_wr_ok | output | 1 | Status register write permitted |

## Verification
The latch responds one edge after a command, so the bench drives commands at a falling edge and reads `wel` at the next falling edge. The permits are combinational from the address, level and `prot_en`, so they are read half a cycle after those inputs change. The pin path takes two edges. The bench reads `status_wr_ok` after one edge, expecting the old value, and again after the second edge, expecting the new value, which pins down the latency exactly.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int ADDR_W = 16;
    localparam int MEM_AW = 14;
    localparam int LVL_W  = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE    = 2'd0,
        LVL_QUARTER = 2'd1,
        LVL_HALF    = 2'd2,
        LVL_ALL     = 2'd3
    } blk_lvl_e;

    typedef struct packed {
        logic              prot_en;
        blk_lvl_e          lvl;
        logic [MEM_AW-1:0] addr;
    } wp_req_t;

    typedef struct packed {
        logic array_ok;
        logic status_ok;
    } wp_grant_t;

    // Lowest value of the two top array-address bits that falls inside the field
    function automatic logic [1:0] field_floor(blk_lvl_e lvl);
        case (lvl)
            LVL_QUARTER: field_floor = 2'd3;
            LVL_HALF:    field_floor = 2'd2;
            default:     field_floor = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= RST_VAL;
                    else     chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= RST_VAL;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

    // R1: synchroniser output returns to its reset value
    a_r1_sync_reset: assert property (@(posedge clk) rst |=> (q_sync == RST_VAL));
endmodule

// File: rtl/wp_enable_latch.sv
module wp_enable_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic disable_i,
    input  logic cycle_done_i,
    output logic wel_o
);
    logic wel_q;
    logic clr_any;

    assign clr_any = disable_i | cycle_done_i;

    always_ff @(posedge clk) begin
        if (rst)          wel_q <= 1'b0;
        else if (clr_any) wel_q <= 1'b0;
        else if (set_i)   wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

    a_r1_latch_reset: assert property (@(posedge clk) rst |=> !wel_o);
    a_r2_set_latch: assert property (@(posedge clk) disable iff (rst)
        (set_i && !disable_i && !cycle_done_i) |=> wel_o);
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (disable_i || cycle_done_i) |=> !wel_o);
endmodule

// File: rtl/wp_region_check.sv
module wp_region_check
    import wp_pkg::*;
(
    input  wp_req_t req_i,
    output logic    in_field_o
);
    logic [1:0] top_bits;
    logic [1:0] floor_v;

    assign top_bits   = req_i.addr[MEM_AW-1 -: 2];
    assign floor_v    = field_floor(req_i.lvl);
    assign in_field_o = (req_i.lvl != LVL_NONE) && (top_bits >= floor_v);

    // R8: whole-array level protects every address; no level protects none
    always_comb begin
        if (req_i.lvl == LVL_ALL)  a_r8_all_protected: assert (in_field_o);
        if (req_i.lvl == LVL_NONE) a_r8_none_protected: assert (!in_field_o);
    end
endmodule

// File: rtl/wp_decision_unit.sv
module wp_decision_unit
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin,
    input  logic              prot_en,
    input  logic [LVL_W-1:0]  blk_lvl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cmd_set_wel,
    input  logic              cmd_clr_wel,
    input  logic              wr_cycle_done,
    output logic              wel,
    output logic              array_wr_ok,
    output logic              status_wr_ok
);
    logic      pin_s;
    logic      in_field;
    logic      wel_q;
    wp_req_t   req;
    wp_grant_t grant;
    logic      unused_addr_hi;

    assign unused_addr_hi = ^wr_addr[ADDR_W-1:MEM_AW];

    assign req.prot_en = prot_en;
    assign req.lvl     = blk_lvl_e'(blk_lvl);
    assign req.addr    = wr_addr[MEM_AW-1:0];

    wp_pin_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (wp_pin),
        .q_sync  (pin_s)
    );

    wp_enable_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .set_i        (cmd_set_wel),
        .disable_i    (cmd_clr_wel),
        .cycle_done_i (wr_cycle_done),
        .wel_o        (wel_q)
    );

    wp_region_check u_region (
        .req_i      (req),
        .in_field_o (in_field)
    );

    always_comb begin
        grant.array_ok  = wel_q && !in_field;
        grant.status_ok = wel_q && (!req.prot_en || pin_s);
    end

    assign wel          = wel_q;
    assign array_wr_ok  = grant.array_ok;
    assign status_wr_ok = grant.status_ok;

    a_r4_no_perm_without_wel: assert property (@(posedge clk) disable iff (rst)
        !wel |-> (!array_wr_ok && !status_wr_ok));
    a_r6_pin_locks_status: assert property (@(posedge clk) disable iff (rst)
        (prot_en && !pin_s) |-> !status_wr_ok);
    a_r8_field_blocks_array: assert property (@(posedge clk) disable iff (rst)
        in_field |-> !array_wr_ok);
endmodule

// File: tb/wp_decision_unit_tb_top.sv
module wp_decision_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wp_pin = 1'b1;
    logic        prot_en = 1'b0;
    logic [1:0]  blk_lvl = 2'd0;
    logic [15:0] wr_addr = 16'h0000;
    logic        cmd_set_wel = 1'b0;
    logic        cmd_clr_wel = 1'b0;
    logic        wr_cycle_done = 1'b0;
    logic        wel, array_wr_ok, status_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wp_decision_unit dut_i (
        .clk(clk), .rst(rst), .wp_pin(wp_pin), .prot_en(prot_en),
        .blk_lvl(blk_lvl), .wr_addr(wr_addr), .cmd_set_wel(cmd_set_wel),
        .cmd_clr_wel(cmd_clr_wel), .wr_cycle_done(wr_cycle_done),
        .wel(wel), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_set();
        cmd_set_wel = 1'b1; step(1); cmd_set_wel = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3);
        chk("R1 wel", wel, 1'b0);
        chk("R1 array", array_wr_ok, 1'b0);
        chk("R1 status", status_wr_ok, 1'b0);
        rst = 1'b0; step(3);
    endtask

    task automatic t_no_wel();
        prot_en = 1'b0; wp_pin = 1'b1; blk_lvl = 2'd0; wr_addr = 16'h0100; step(1);
        chk("R4 array", array_wr_ok, 1'b0);
        chk("R4 status", status_wr_ok, 1'b0);
    endtask

    task automatic t_set();
        chk("R2 before", wel, 1'b0);
        pulse_set();
        chk("R2 wel", wel, 1'b1);
    endtask

    task automatic t_unarmed();
        prot_en = 1'b0; blk_lvl = 2'd0;
        wp_pin = 1'b0; step(3);
        chk("R5 status pin low", status_wr_ok, 1'b1);
        chk("R5 array", array_wr_ok, 1'b1);
        wp_pin = 1'b1; step(3);
        chk("R5 status pin high", status_wr_ok, 1'b1);
    endtask

    task automatic t_armed();
        prot_en = 1'b1; wp_pin = 1'b0; blk_lvl = 2'd0; step(3);
        chk("R6 status locked", status_wr_ok, 1'b0);
        chk("R6 array", array_wr_ok, 1'b1);
        blk_lvl = 2'd2; wr_addr = 16'h2000; step(1);
        chk("R6 array in field", array_wr_ok, 1'b0);
        blk_lvl = 2'd0; wr_addr = 16'h0000;
        wp_pin = 1'b1; step(3);
        chk("R7 status pin high", status_wr_ok, 1'b1);
    endtask

    task automatic t_levels();
        logic [15:0] addrs [8] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h2FFF,
                                   16'h3000, 16'h3FFF, 16'hC000, 16'hF000};
        prot_en = 1'b0;
        for (int l = 0; l < 4; l++) begin
            for (int k = 0; k < 8; k++) begin
                logic [13:0] a;
                logic prot;
                blk_lvl = l[1:0]; wr_addr = addrs[k]; a = addrs[k][13:0];
                case (l)
                    1: prot = (a >= 14'h3000);
                    2: prot = (a >= 14'h2000);
                    3: prot = 1'b1;
                    default: prot = 1'b0;
                endcase
                step(1);
                chk($sformatf("R8 lvl%0d addr %h", l, addrs[k]), array_wr_ok, !prot);
            end
        end
        blk_lvl = 2'd0;
    endtask

    task automatic t_sync();
        prot_en = 1'b1; wp_pin = 1'b1; step(3);
        chk("R9 start", status_wr_ok, 1'b1);
        wp_pin = 1'b0; step(1);
        chk("R9 after one edge", status_wr_ok, 1'b1);
        step(1);
        chk("R9 after two edges", status_wr_ok, 1'b0);
        wp_pin = 1'b1; step(1);
        chk("R9 release one edge", status_wr_ok, 1'b0);
        step(1);
        chk("R9 release two edges", status_wr_ok, 1'b1);
        prot_en = 1'b0;
    endtask

    task automatic t_clear();
        cmd_clr_wel = 1'b1; step(1); cmd_clr_wel = 1'b0;
        chk("R3 disable", wel, 1'b0);
        pulse_set();
        wr_cycle_done = 1'b1; step(1); wr_cycle_done = 1'b0;
        chk("R3 cycle done", wel, 1'b0);
        cmd_set_wel = 1'b1; cmd_clr_wel = 1'b1; step(1);
        cmd_set_wel = 1'b0; cmd_clr_wel = 1'b0;
        chk("R3 disable beats set", wel, 1'b0);
        cmd_set_wel = 1'b1; wr_cycle_done = 1'b1; step(1);
        cmd_set_wel = 1'b0; wr_cycle_done = 1'b0;
        chk("R3 done beats set", wel, 1'b0);
        wr_addr = 16'h0000; prot_en = 1'b0; wp_pin = 1'b1; step(3);
        chk("R4 after clear array", array_wr_ok, 1'b0);
        chk("R4 after clear status", status_wr_ok, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1);
        t_reset();
        t_no_wel();
        t_set();
        t_unarmed();
        t_armed();
        t_levels();
        t_sync();
        t_clear();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule